// File: doc/BRIEF.md
# PWM Fault Guard

This block sits between a set of PWM generator outputs and the pins they drive. It watches a small group of asynchronous fault pins and a group of synchronous comparator trigger lines. While a fault condition holds, it replaces each chosen output with a programmed safe level. Outputs that are not chosen pass through unchanged, delayed by one register stage. Software configures it through a simple write port with an address and 32-bit data.

The fault condition comes from one of two sources. The first is a single global source, pin 0 after its polarity setting. The second is the OR of the selected pins and the selected comparator lines. A detected fault can be made to persist until software clears it, or it can be stretched to a programmed minimum number of clock cycles. Sticky status bits show which inputs took part in a fault. A flag records each fault onset and drives an interrupt through an enable.

Register map (the word address is `wr_addr`):
- 0, control: bit0 selects the combined source (0 = global pin 0), bit1 enables the latch, bit2 enables stretching.
- 1, pins: bits[3:0] invert the pins (1 = active low), bits[11:8] are the pin selection mask.
- 2, comparators: bits[7:0] are the comparator selection mask.
- 3, minimum length: bits[15:0].
- 4, override: bits[7:0] choose the outputs to force, bits[15:8] are the safe levels.
- 5, clear: write 1 to clear. Bits[3:0] clear pin status, bits[15:8] clear comparator status, and bit16 clears the fault flag and the latch.
- 6, interrupt enable: bit0.

Top module: `pwm_fault_guard`

## Requirements
- R1: A change on a fault pin passes a two-flop synchroniser and appears on `fault_active_o` after the third rising edge. A comparator line passes one register and appears after the second rising edge.
- R2: Each pin's invert bit (register 1, bits[3:0]) sets its active level. 0 means active high and 1 means active low.
- R3: With control bit0 = 0, only pin 0 after its polarity causes a fault, whatever the masks and the comparators. With bit0 = 1, the fault is the OR of the active selected pins and the active selected comparator lines.
- R4: A pin or comparator line whose mask bit is 0 causes no fault and sets no status bit.
- R5: With control bit1 = 1, any fault holds `fault_active_o` high until a write sets clear bit16. After that write it drops one cycle later, provided no source is still active.
- R6: With control bit2 = 1 and minimum length P ≥ 1, a one-cycle source gives exactly P cycles of fault. A new source while the stretch is running restarts it, so a second pulse G cycles after the first gives G+P cycles. With bit2 = 0 the fault lasts only as long as its source.
- R7: Each registered output `pwm_o` is `pwm_i` from the cycle before. In a fault cycle, each bit selected in register 4 bits[7:0] takes its safe level from bits[15:8] instead.
- R8: Status bits are sticky. A bit is set while its input takes part in a fault (pin 0 alone in global mode) and cleared only by writing 1 to its clear bit. A set in the same cycle wins over the clear.
- R9: Each fault onset sets the fault flag. The flag is cleared by clear bit16. `irq_o` is the flag ANDed with the enable bit.
- R10: After reset all registers are 0. No fault is reported, no status bit or interrupt is set, and `pwm_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_pin_i | input | 4 | Asynchronous fault pins |
| cmp_trig_i | input | 8 | Synchronous comparator trigger lines |
| pwm_i | input | 8 | PWM signals from the generators |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| pwm_o | output | 8 | Registered outputs with fault override |
| fault_active_o | output | 1 | Fault state, registered |
| irq_o | output | 1 | Fault interrupt |
| pin_stat_o | output | 4 | Sticky pin status |
| cmp_stat_o | output | 8 | Sticky comparator status |

## Verification
A pin result is due three rising edges after the pin changes. A comparator result is due two edges after the line changes. A register write takes effect on the fault path one edge after the write edge, and the fault state lags that by one more edge. The bench carries these latencies in a behavioural model: a queue of pin samples, a held comparator sample, and an integer for the remaining stretch. It compares every output at each falling edge against the model state for that edge. The directed checks count falling edges from the stimulus according to these latencies, and measure stretch lengths by counting high cycles over a fixed window.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PIN    = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP    = 3'd2;
  localparam logic [ADDR_W-1:0] A_MINLEN = 3'd3;
  localparam logic [ADDR_W-1:0] A_OVR    = 3'd4;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 3'd5;
  localparam logic [ADDR_W-1:0] A_IRQEN  = 3'd6;

  localparam int unsigned PIN_MASK_LSB = 8;
  localparam int unsigned OVR_SAFE_LSB = 8;
  localparam int unsigned CLR_CMP_LSB  = 8;
  localparam int unsigned CLR_FLAG_BIT = 16;

  typedef struct packed {
    logic comb_src;
    logic latch_en;
    logic stretch_en;
    logic irq_en;
  } guard_ctrl_t;
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/pfg_regs.sv
module pfg_regs
  import pfg_pkg::*;
#(
  parameter int unsigned N_PIN = 4,
  parameter int unsigned N_CMP = 8,
  parameter int unsigned N_OUT = 8,
  parameter int unsigned PER_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output guard_ctrl_t       ctrl,
  output logic [N_PIN-1:0]  pin_inv,
  output logic [N_PIN-1:0]  pin_mask,
  output logic [N_CMP-1:0]  cmp_mask,
  output logic [PER_W-1:0]  min_len,
  output logic [N_OUT-1:0]  ovr_sel,
  output logic [N_OUT-1:0]  safe_val,
  output logic [N_PIN-1:0]  clr_pin,
  output logic [N_CMP-1:0]  clr_cmp,
  output logic              clr_flag
);
  logic clr_hit;
  logic unused_wr_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      pin_inv  <= '0;
      pin_mask <= '0;
      cmp_mask <= '0;
      min_len  <= '0;
      ovr_sel  <= '0;
      safe_val <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          ctrl.comb_src   <= wr_data[0];
          ctrl.latch_en   <= wr_data[1];
          ctrl.stretch_en <= wr_data[2];
        end
        A_PIN: begin
          pin_inv  <= wr_data[N_PIN-1:0];
          pin_mask <= wr_data[PIN_MASK_LSB +: N_PIN];
        end
        A_CMP:    cmp_mask <= wr_data[N_CMP-1:0];
        A_MINLEN: min_len  <= wr_data[PER_W-1:0];
        A_OVR: begin
          ovr_sel  <= wr_data[N_OUT-1:0];
          safe_val <= wr_data[OVR_SAFE_LSB +: N_OUT];
        end
        A_IRQEN:  ctrl.irq_en <= wr_data[0];
        default: ;
      endcase
    end
  end

  // write-one-to-clear strobes, valid for the write cycle only
  assign clr_hit  = wr_en && (wr_addr == A_CLEAR);
  assign clr_pin  = clr_hit ? wr_data[N_PIN-1:0] : '0;
  assign clr_cmp  = clr_hit ? wr_data[CLR_CMP_LSB +: N_CMP] : '0;
  assign clr_flag = clr_hit && wr_data[CLR_FLAG_BIT];

  assign unused_wr_bits = ^wr_data;
endmodule

// File: rtl/pfg_qual.sv
module pfg_qual #(
  parameter int unsigned N_PIN = 4,
  parameter int unsigned N_CMP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_PIN-1:0] pin_sync,
  input  logic [N_CMP-1:0] cmp_trig,
  input  logic             comb_src,
  input  logic [N_PIN-1:0] pin_inv,
  input  logic [N_PIN-1:0] pin_mask,
  input  logic [N_CMP-1:0] cmp_mask,
  output logic [N_PIN-1:0] pin_hit,
  output logic [N_CMP-1:0] cmp_hit,
  output logic             raw
);
  logic [N_CMP-1:0] cmp_q;
  logic [N_PIN-1:0] pin_act;

  always_ff @(posedge clk) begin
    if (rst) cmp_q <= '0;
    else     cmp_q <= cmp_trig;
  end

  assign pin_act = pin_sync ^ pin_inv;
  // global mode: pin 0 only, no masks, no comparators
  assign pin_hit = comb_src ? (pin_act & pin_mask) : (pin_act & N_PIN'(1));
  assign cmp_hit = comb_src ? (cmp_q & cmp_mask) : '0;
  assign raw     = (|pin_hit) | (|cmp_hit);
endmodule

// File: rtl/pfg_hold.sv
module pfg_hold #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw,
  input  logic             latch_en,
  input  logic             stretch_en,
  input  logic [PER_W-1:0] min_len,
  input  logic             clr_flag,
  output logic             fault_d,
  output logic             fault_q
);
  logic [PER_W-1:0] cnt;
  logic             latch_q;
  logic             stretching;

  assign stretching = stretch_en && (cnt != '0);
  assign fault_d    = raw || stretching || latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      latch_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      if (raw)             cnt <= (min_len == '0) ? '0 : min_len - PER_W'(1);
      else if (cnt != '0)  cnt <= cnt - PER_W'(1);
      if (raw && latch_en) latch_q <= 1'b1;
      else if (clr_flag)   latch_q <= 1'b0;
      fault_q <= fault_d;
    end
  end

  // R6
  stretch_load_chk: assert property (@(posedge clk) disable iff (rst)
    (raw && (min_len > PER_W'(1))) |=> (cnt != '0));

  // R5
  latch_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_q && !clr_flag) |=> latch_q);
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import pfg_pkg::*;
#(
  parameter int unsigned N_PIN = 4,
  parameter int unsigned N_CMP = 8,
  parameter int unsigned N_OUT = 8,
  parameter int unsigned PER_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PIN-1:0]  fault_pin_i,
  input  logic [N_CMP-1:0]  cmp_trig_i,
  input  logic [N_OUT-1:0]  pwm_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [N_OUT-1:0]  pwm_o,
  output logic              fault_active_o,
  output logic              irq_o,
  output logic [N_PIN-1:0]  pin_stat_o,
  output logic [N_CMP-1:0]  cmp_stat_o
);
  guard_ctrl_t      ctrl;
  logic [N_PIN-1:0] pin_inv, pin_mask, pin_sync, pin_hit, clr_pin;
  logic [N_CMP-1:0] cmp_mask, cmp_hit, clr_cmp;
  logic [PER_W-1:0] min_len;
  logic [N_OUT-1:0] ovr_sel, safe_val, pwm_nx;
  logic             clr_flag, raw, fault_d, fault_q, irq_flag;

  pfg_regs #(.N_PIN(N_PIN), .N_CMP(N_CMP), .N_OUT(N_OUT), .PER_W(PER_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl(ctrl), .pin_inv(pin_inv), .pin_mask(pin_mask), .cmp_mask(cmp_mask),
    .min_len(min_len), .ovr_sel(ovr_sel), .safe_val(safe_val),
    .clr_pin(clr_pin), .clr_cmp(clr_cmp), .clr_flag(clr_flag));

  pfg_sync #(.W(N_PIN)) u_sync (
    .clk(clk), .rst(rst), .async_i(fault_pin_i), .sync_o(pin_sync));

  pfg_qual #(.N_PIN(N_PIN), .N_CMP(N_CMP)) u_qual (
    .clk(clk), .rst(rst), .pin_sync(pin_sync), .cmp_trig(cmp_trig_i),
    .comb_src(ctrl.comb_src), .pin_inv(pin_inv), .pin_mask(pin_mask),
    .cmp_mask(cmp_mask), .pin_hit(pin_hit), .cmp_hit(cmp_hit), .raw(raw));

  pfg_hold #(.PER_W(PER_W)) u_hold (
    .clk(clk), .rst(rst), .raw(raw), .latch_en(ctrl.latch_en),
    .stretch_en(ctrl.stretch_en), .min_len(min_len), .clr_flag(clr_flag),
    .fault_d(fault_d), .fault_q(fault_q));

  for (genvar g = 0; g < N_OUT; g++) begin : g_ovr
    assign pwm_nx[g] = (fault_d && ovr_sel[g]) ? safe_val[g] : pwm_i[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_o      <= '0;
      pin_stat_o <= '0;
      cmp_stat_o <= '0;
      irq_flag   <= 1'b0;
    end else begin
      pwm_o      <= pwm_nx;
      pin_stat_o <= (pin_stat_o & ~clr_pin) | pin_hit;
      cmp_stat_o <= (cmp_stat_o & ~clr_cmp) | cmp_hit;
      if (fault_d && !fault_q) irq_flag <= 1'b1;
      else if (clr_flag)       irq_flag <= 1'b0;
    end
  end

  assign fault_active_o = fault_q;
  assign irq_o          = irq_flag & ctrl.irq_en;

  // R7
  ovr_safe_chk: assert property (@(posedge clk) disable iff (rst)
    fault_d |=> ((pwm_o & $past(ovr_sel)) == ($past(safe_val) & $past(ovr_sel))));

  // R7
  pass_chk: assert property (@(posedge clk) disable iff (rst)
    !fault_d |=> (pwm_o == $past(pwm_i)));

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_active_o) |-> irq_flag);

  // R8
  stat_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_pin == '0) |=> ((pin_stat_o & $past(pin_stat_o)) == $past(pin_stat_o)));
endmodule

// File: tb/sim_pwm_fault_guard.sv
`timescale 1ns/1ps
module sim_pwm_fault_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  fault_pin_i = '0;
  logic [7:0]  cmp_trig_i = '0;
  logic [7:0]  pwm_i = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  pwm_o;
  logic        fault_active_o, irq_o;
  logic [3:0]  pin_stat_o;
  logic [7:0]  cmp_stat_o;

  int n_run = 0;
  int n_fail = 0;
  int hi_cnt = 0;

  always #2.5 clk = ~clk;

  pwm_fault_guard u0 (
    .clk(clk), .rst(rst), .fault_pin_i(fault_pin_i), .cmp_trig_i(cmp_trig_i),
    .pwm_i(pwm_i), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_o(pwm_o), .fault_active_o(fault_active_o), .irq_o(irq_o),
    .pin_stat_o(pin_stat_o), .cmp_stat_o(cmp_stat_o));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [3:0] pin_hist[$];
  logic [7:0] cmp_seen;
  logic       m_ready = 1'b0;
  logic       m_comb, m_lat, m_str, m_ien;
  logic [3:0] m_inv, m_pmask, m_pstat;
  logic [7:0] m_cmask, m_sel, m_safe, m_cstat, m_pwm;
  int         m_len, rem;
  logic       m_latch, m_fault, m_flag;

  always @(posedge clk) begin
    logic [3:0] act, ph;
    logic [7:0] ch;
    logic raw, flt, clr_f;
    logic [3:0] clr_p;
    logic [7:0] clr_c;
    if (rst) begin
      pin_hist = {};
      pin_hist.push_back(4'h0);
      pin_hist.push_back(4'h0);
      cmp_seen = '0;
      {m_comb, m_lat, m_str, m_ien} = '0;
      m_inv = '0; m_pmask = '0; m_cmask = '0; m_sel = '0; m_safe = '0;
      m_len = 0; rem = 0; m_latch = 0; m_fault = 0; m_flag = 0;
      m_pstat = '0; m_cstat = '0; m_pwm = '0;
      m_ready = 1'b1;
    end else begin
      act = pin_hist[0] ^ m_inv;
      if (m_comb) begin ph = act & m_pmask; ch = cmp_seen & m_cmask; end
      else        begin ph = {3'b000, act[0]}; ch = '0; end
      raw   = (ph != 0) || (ch != 0);
      flt   = raw || (m_str && rem > 0) || m_latch;
      clr_f = wr_en && wr_addr == 3'd5 && wr_data[16];
      clr_p = (wr_en && wr_addr == 3'd5) ? wr_data[3:0] : 4'h0;
      clr_c = (wr_en && wr_addr == 3'd5) ? wr_data[15:8] : 8'h0;
      m_pwm = flt ? ((pwm_i & ~m_sel) | (m_safe & m_sel)) : pwm_i;
      if (raw) rem = (m_len > 0) ? m_len - 1 : 0;
      else if (rem > 0) rem--;
      if (raw && m_lat) m_latch = 1; else if (clr_f) m_latch = 0;
      if (flt && !m_fault) m_flag = 1; else if (clr_f) m_flag = 0;
      m_fault = flt;
      m_pstat = (m_pstat & ~clr_p) | ph;
      m_cstat = (m_cstat & ~clr_c) | ch;
      void'(pin_hist.pop_front());
      pin_hist.push_back(fault_pin_i);
      cmp_seen = cmp_trig_i;
      if (wr_en) begin
        case (wr_addr)
          3'd0: {m_str, m_lat, m_comb} = wr_data[2:0];
          3'd1: begin m_inv = wr_data[3:0]; m_pmask = wr_data[11:8]; end
          3'd2: m_cmask = wr_data[7:0];
          3'd3: m_len = int'(wr_data[15:0]);
          3'd4: begin m_sel = wr_data[7:0]; m_safe = wr_data[15:8]; end
          3'd6: m_ien = wr_data[0];
          default: ;
        endcase
      end
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (m_ready) begin
      chk("R7", "pwm_o", 32'(pwm_o), 32'(m_pwm));
      chk("R3", "fault_active_o", 32'(fault_active_o), 32'(m_fault));
      chk("R8", "pin_stat_o", 32'(pin_stat_o), 32'(m_pstat));
      chk("R8", "cmp_stat_o", 32'(cmp_stat_o), 32'(m_cstat));
      chk("R9", "irq_o", 32'(irq_o), 32'(m_flag & m_ien));
    end
    if (fault_active_o === 1'b1) hi_cnt++;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic cmp_pulse();
    cmp_trig_i = 8'h80;
    @(negedge clk);
    cmp_trig_i = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(4);
    // R10 reset state
    chk("R10", "fault", 32'(fault_active_o), 0);
    chk("R10", "pwm_o", 32'(pwm_o), 0);
    chk("R10", "status", 32'({pin_stat_o, cmp_stat_o}), 0);
    chk("R10", "irq", 32'(irq_o), 0);
    rst = 1'b0;

    // R7 pass-through
    for (int i = 0; i < 20; i++) begin pwm_i = 8'($urandom); @(negedge clk); end
    pwm_i = 8'h3C; @(negedge clk);
    chk("R7", "pass", 32'(pwm_o), 32'h3C);

    wr(3'd4, 32'h0000_A5F0);
    wr(3'd6, 32'h1);

    // R1 synchroniser latency on pin 0 (global mode)
    pwm_i = 8'h0F;
    fault_pin_i = 4'b0001;
    idle(2);
    chk("R1", "fault before 3rd edge", 32'(fault_active_o), 0);
    idle(1);
    chk("R1", "fault at 3rd edge", 32'(fault_active_o), 1);
    chk("R7", "override", 32'(pwm_o), 32'hAF);
    chk("R9", "irq on onset", 32'(irq_o), 1);
    chk("R8", "pin0 status", 32'(pin_stat_o), 32'h1);
    fault_pin_i = 4'b0000;
    idle(4);
    chk("R1", "fault released", 32'(fault_active_o), 0);
    chk("R7", "pass after fault", 32'(pwm_o), 32'h0F);
    wr(3'd5, 32'h0001_FF0F);
    chk("R8", "status cleared", 32'(pin_stat_o), 0);
    chk("R9", "irq cleared", 32'(irq_o), 0);

    // R2 polarity: pin 0 inverted makes low pin active
    wr(3'd1, 32'h0000_0001);
    idle(1);
    chk("R2", "inverted pin active", 32'(fault_active_o), 1);
    wr(3'd1, 32'h0);
    idle(3);
    chk("R2", "normal polarity idle", 32'(fault_active_o), 0);
    wr(3'd5, 32'h0001_FF0F);

    // R3 global mode ignores other pins and comparators
    fault_pin_i = 4'b1110; cmp_trig_i = 8'hFF;
    idle(4);
    chk("R3", "global ignores others", 32'(fault_active_o), 0);
    chk("R4", "no comparator status", 32'(cmp_stat_o), 0);

    // R3/R4 combined mode with masks
    wr(3'd1, 32'h0000_0400);
    wr(3'd2, 32'h0000_0080);
    wr(3'd0, 32'h1);
    idle(3);
    chk("R3", "combined fault", 32'(fault_active_o), 1);
    chk("R4", "masked pin status", 32'(pin_stat_o), 32'h4);
    chk("R4", "masked cmp status", 32'(cmp_stat_o), 32'h80);
    fault_pin_i = 4'b1010; cmp_trig_i = 8'h7F;
    idle(4);
    chk("R4", "unselected inputs ignored", 32'(fault_active_o), 0);
    wr(3'd5, 32'h0001_FF0F);
    idle(2);
    chk("R8", "stays clear with unselected active", 32'({pin_stat_o, cmp_stat_o}), 0);
    fault_pin_i = 4'b0000; cmp_trig_i = 8'h00;
    idle(3);

    // R9 enable gating
    wr(3'd5, 32'h0001_0000);
    wr(3'd6, 32'h0);
    cmp_pulse();
    idle(3);
    chk("R9", "irq masked", 32'(irq_o), 0);
    wr(3'd6, 32'h1);
    chk("R9", "flag sticky, irq shown", 32'(irq_o), 1);
    wr(3'd5, 32'h0001_0000);
    chk("R9", "irq cleared", 32'(irq_o), 0);

    // R5 latch
    wr(3'd0, 32'h3);
    cmp_pulse();
    idle(30);
    chk("R5", "latched", 32'(fault_active_o), 1);
    wr(3'd5, 32'h0001_0000);
    idle(1);
    chk("R5", "released after clear", 32'(fault_active_o), 0);

    // R6 stretch
    wr(3'd0, 32'h5);
    wr(3'd3, 32'd20);
    idle(2);
    hi_cnt = 0;
    cmp_pulse();
    idle(60);
    chk("R6", "single pulse length", 32'(hi_cnt), 32'd20);
    hi_cnt = 0;
    cmp_pulse();
    idle(9);
    cmp_pulse();
    idle(60);
    chk("R6", "restart length", 32'(hi_cnt), 32'd30);
    wr(3'd3, 32'd1);
    idle(2);
    hi_cnt = 0;
    cmp_pulse();
    idle(10);
    chk("R6", "length one", 32'(hi_cnt), 32'd1);
    wr(3'd3, 32'd20);
    wr(3'd0, 32'h1);
    idle(2);
    hi_cnt = 0;
    cmp_pulse();
    idle(30);
    chk("R6", "stretch disabled", 32'(hi_cnt), 32'd1);

    // mixed random traffic, compared every cycle against the model
    for (int i = 0; i < 3000; i++) begin
      pwm_i = 8'($urandom);
      if ($urandom_range(0, 9) == 0) fault_pin_i = 4'($urandom);
      cmp_trig_i = ($urandom_range(0, 15) == 0) ? 8'($urandom) : 8'h00;
      if ($urandom_range(0, 39) == 0) begin
        case ($urandom_range(0, 5))
          0: wr(3'd0, 32'($urandom_range(0, 7)));
          1: wr(3'd1, 32'($urandom) & 32'h0F0F);
          2: wr(3'd2, 32'($urandom));
          3: wr(3'd3, 32'($urandom_range(0, 25)));
          4: wr(3'd4, 32'($urandom));
          default: wr(3'd5, 32'($urandom));
        endcase
      end else begin
        @(negedge clk);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule